// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits between a host that wants to read or write PCI configuration registers and a plain memory-mapped bus that reaches the PCI side through a fixed configuration aperture. A request names a bus, device, function, register offset, a byte count and, for writes, the data. The block first checks that the request can be carried. It then loads a window register that tells the bridge which configuration cycle type to emit and forms the aperture address. Finally it performs one 32-bit bus access, or two for a partial write.

For bus 0 the block emits type 0 cycles. The slot is chosen by a one-hot select bit at position device+16. The upper part of that bit, under a fixed mask, travels in the window register and the lower part travels in the address. For any other bus number it emits type 1 cycles, with bus, device and function packed into the address. Reads return the requested bytes shifted down to bit 0. Partial writes read the word, merge in the new bytes and write the word back. A mode input restricts the bridge to the single device 0, for slots that carry only one card. The block handles one request at a time.

Top module: `pcicfg_xlate`

## Requirements
- R1: A request whose size is not 1, 2 or 4 completes with status 1 (invalid) and makes no downstream access.
- R2: With bus number 0, a device number of 16 or more completes with status 2 (not found). Otherwise the window becomes 0x2 | (S & 0xFC000000) and the address becomes 0x0C000000 | (S & 0x03FFFFFF) | function<<8 | (offset & 0xFC), where S = 1<<(device+16).
- R3: With a nonzero bus number, the window becomes 0x3 and the address becomes 0x0C000000 | bus<<16 | device<<11 | function<<8 | (offset & 0xFC).
- R4: When cardbus_mode is high, any device number other than 0 completes with status 2, whatever the bus number.
- R5: A read returns the fetched word shifted right by 8×(offset & 3), masked to 8 bits for size 1 and 16 bits for size 2, with status 0.
- R6: A 1- or 2-byte write performs one read and then one write of the same address. The written word is the read word with the 0xFF or 0xFFFF lane at bit 8×(offset & 3) replaced by the low bytes of the write data.
- R7: A 4-byte write performs exactly one downstream write of the write data and no read.
- R8: A downstream error (mem_err with mem_ack) completes the request with status 3 and response data 0xFFFFFFFF. An error on the read phase of a partial write suppresses the write.
- R9: A request that completes with status 1 or 2 leaves the window register unchanged.
- R10: busy is high from the cycle after acceptance until the cycle after rsp_valid. Requests presented while busy are ignored, and rsp_valid is a single-cycle pulse per accepted request.
- R11: After reset, busy, rsp_valid and mem_req are low and the window register holds 0x2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = configuration write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_func | input | 3 | Target function number |
| req_off | input | 8 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right aligned |
| cardbus_mode | input | 1 | Only device 0 is reachable |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 0 ok, 1 invalid, 2 not found, 3 bus error |
| rsp_rdata | output | 32 | Read result, right aligned |
| win_reg | output | 32 | Window register driving the bridge cycle type |
| mem_req | output | 1 | Downstream access request, held until mem_ack |
| mem_we | output | 1 | Downstream write enable |
| mem_addr | output | 32 | Downstream word address inside the aperture |
| mem_wdata | output | 32 | Downstream write word |
| mem_rdata | input | 32 | Downstream read word |
| mem_ack | input | 1 | Downstream access complete |
| mem_err | input | 1 | Downstream access failed |

## Verification
The bench targets slot 15 on bus 0, whose select bit lands at bit 31 of the window. A split at the wrong mask would move it into the address or drop it. It also targets a 2-byte read at offset 3, where the result must be cut to one byte rather than wrap. Partial writes at nonzero lanes are checked, since a wrong lane shift or a missing read phase would clobber neighbouring bytes. An error on the read phase of a partial write must produce no write, and a design that wrote anyway would store a merge of garbage. Rejected requests, a second request arriving while busy, and device 1 behind the single-slot mode on a nonzero bus must all leave the window and the bus access counts untouched.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FUNC_W = 3;
    localparam int OFF_W  = 8;
    localparam int SIZE_W = 3;

    localparam logic [ADDR_W-1:0] DEF_APERTURE = 32'h0C00_0000;
    localparam logic [DATA_W-1:0] DEF_WIN_MASK = 32'hFC00_0000;
    localparam logic [DATA_W-1:0] DEF_CODE_T0  = 32'h0000_0002;
    localparam logic [DATA_W-1:0] DEF_CODE_T1  = 32'h0000_0003;
    localparam int                DEF_SLOTS    = 16;

    typedef enum logic [1:0] {
        CST_OK       = 2'd0,
        CST_INVAL    = 2'd1,
        CST_NOTFOUND = 2'd2,
        CST_BUSERR   = 2'd3
    } cfg_status_e;

    typedef enum logic [1:0] {
        S_IDLE, S_RD, S_WR, S_DONE
    } xl_state_e;

    typedef struct packed {
        logic [BUS_W-1:0]  bus;
        logic [DEV_W-1:0]  dev;
        logic [FUNC_W-1:0] func;
        logic [OFF_W-1:0]  off;
    } cfg_loc_t;

    typedef struct packed {
        logic              found;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] win;
    } cfg_dec_t;

    typedef struct packed {
        logic              write;
        logic [SIZE_W-1:0] size;
        logic [1:0]        lane;
        logic [DATA_W-1:0] wdata;
    } cfg_pend_t;

    function automatic logic size_legal(input logic [SIZE_W-1:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

    function automatic logic [DATA_W-1:0] size_keep(input logic [SIZE_W-1:0] sz);
        case (sz)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/pcicfg_addr_gen.sv
module pcicfg_addr_gen
    import pcicfg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] APERTURE = DEF_APERTURE,
    parameter logic [DATA_W-1:0] WIN_MASK = DEF_WIN_MASK,
    parameter logic [DATA_W-1:0] CODE_T0  = DEF_CODE_T0,
    parameter logic [DATA_W-1:0] CODE_T1  = DEF_CODE_T1,
    parameter int                SLOTS    = DEF_SLOTS
) (
    input  cfg_loc_t loc,
    input  logic     single_slot,
    output cfg_dec_t dec
);
    localparam int SEL_BASE = 16;

    logic [5:0]        sel_pos;
    logic [DATA_W-1:0] sel_bit;
    logic [ADDR_W-1:0] low_part;

    always_comb begin
        sel_pos  = 6'(loc.dev) + 6'(SEL_BASE);
        sel_bit  = 32'd1 << sel_pos;
        low_part = (32'(loc.func) << 8) | 32'(loc.off & 8'hFC);
        dec.found = 1'b1;
        if (single_slot && (loc.dev != '0))
            dec.found = 1'b0;
        if (loc.bus == '0) begin
            if (32'(loc.dev) >= SLOTS)
                dec.found = 1'b0;
            dec.win  = CODE_T0 | (sel_bit & WIN_MASK);
            dec.addr = APERTURE | (sel_bit & ~WIN_MASK) | low_part;
        end else begin
            dec.win  = CODE_T1;
            dec.addr = APERTURE | (32'(loc.bus) << 16) | (32'(loc.dev) << 11) | low_part;
        end
    end
endmodule

// File: rtl/pcicfg_lane.sv
module pcicfg_lane
    import pcicfg_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  logic [1:0]        lane,
    input  logic [SIZE_W-1:0] size,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_val,
    output logic [DATA_W-1:0] merged
);
    logic [4:0]        sh;
    logic [DATA_W-1:0] keep;

    always_comb begin
        sh     = {lane, 3'b000};
        keep   = size_keep(size);
        rd_val = (word >> sh) & keep;
        merged = (word & ~(keep << sh)) | ((wdata & keep) << sh);
    end
endmodule

// File: rtl/pcicfg_xlate.sv
module pcicfg_xlate
    import pcicfg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] APERTURE = DEF_APERTURE,
    parameter logic [DATA_W-1:0] WIN_MASK = DEF_WIN_MASK,
    parameter logic [DATA_W-1:0] CODE_T0  = DEF_CODE_T0,
    parameter logic [DATA_W-1:0] CODE_T1  = DEF_CODE_T1,
    parameter int                SLOTS    = DEF_SLOTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FUNC_W-1:0] req_func,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cardbus_mode,
    output logic              busy,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [DATA_W-1:0] win_reg,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err
);
    xl_state_e         state_q;
    cfg_pend_t         pend_q;
    cfg_status_e       status_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] win_q, wword_q, rdata_q;

    cfg_loc_t          loc;
    cfg_dec_t          dec;
    logic [DATA_W-1:0] lane_rd, lane_merged;
    logic              accept;

    assign loc    = '{bus: req_bus, dev: req_dev, func: req_func, off: req_off};
    assign accept = (state_q == S_IDLE) && req_valid;

    pcicfg_addr_gen #(
        .APERTURE(APERTURE), .WIN_MASK(WIN_MASK),
        .CODE_T0(CODE_T0), .CODE_T1(CODE_T1), .SLOTS(SLOTS)
    ) i_addr (
        .loc(loc), .single_slot(cardbus_mode), .dec(dec)
    );

    pcicfg_lane i_lane (
        .word(mem_rdata), .lane(pend_q.lane), .size(pend_q.size),
        .wdata(pend_q.wdata), .rd_val(lane_rd), .merged(lane_merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            pend_q   <= '0;
            status_q <= CST_OK;
            addr_q   <= '0;
            win_q    <= CODE_T0;
            wword_q  <= '0;
            rdata_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (accept) begin
                    pend_q  <= '{write: req_write, size: req_size,
                                 lane: req_off[1:0], wdata: req_wdata};
                    rdata_q <= '0;
                    if (!size_legal(req_size)) begin
                        status_q <= CST_INVAL;
                        state_q  <= S_DONE;
                    end else if (!dec.found) begin
                        status_q <= CST_NOTFOUND;
                        state_q  <= S_DONE;
                    end else begin
                        win_q  <= dec.win;
                        addr_q <= dec.addr;
                        if (req_write && (req_size == 3'd4)) begin
                            wword_q <= req_wdata;
                            state_q <= S_WR;
                        end else begin
                            state_q <= S_RD;
                        end
                    end
                end
                S_RD: if (mem_ack) begin
                    if (mem_err) begin
                        rdata_q  <= '1;
                        status_q <= CST_BUSERR;
                        state_q  <= S_DONE;
                    end else if (pend_q.write) begin
                        wword_q <= lane_merged;
                        state_q <= S_WR;
                    end else begin
                        rdata_q  <= lane_rd;
                        status_q <= CST_OK;
                        state_q  <= S_DONE;
                    end
                end
                S_WR: if (mem_ack) begin
                    if (mem_err) begin
                        rdata_q  <= '1;
                        status_q <= CST_BUSERR;
                    end else begin
                        status_q <= CST_OK;
                    end
                    state_q <= S_DONE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy       = (state_q != S_IDLE);
    assign rsp_valid  = (state_q == S_DONE);
    assign rsp_status = status_q;
    assign rsp_rdata  = rdata_q;
    assign win_reg    = win_q;
    assign mem_req    = (state_q == S_RD) || (state_q == S_WR);
    assign mem_we     = (state_q == S_WR);
    assign mem_addr   = addr_q;
    assign mem_wdata  = wword_q;

    // R1: a rejected size never reaches the downstream bus
    p_no_access_r1: assert property (@(posedge clk) disable iff (rst)
        (accept && !size_legal(req_size)) |=> !mem_req);

    // R2, R3: every aperture access is word aligned
    p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R8: a bus error response carries all ones
    p_err_ones_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_status == CST_BUSERR)) |-> (rsp_rdata == '1));

    // R9: a failed decode leaves the window alone
    p_win_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (accept && !(size_legal(req_size) && dec.found)) |=> $stable(win_reg));

    // R10: the response is a single-cycle pulse
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R10: busy only drops right after a response
    p_busy_drop_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(rsp_valid));
endmodule

// File: tb/test_pcicfg_xlate.sv
`timescale 1ns/1ps
module test_pcicfg_xlate;

    typedef struct packed {
        logic        wr;
        logic        cb;
        logic        err;
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  func;
        logic [7:0]  off;
        logic [2:0]  size;
        logic [31:0] wdata;
        logic [31:0] mem;
        logic [1:0]  exp_st;
        logic [31:0] exp_rd;
        logic [31:0] exp_word;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,8'd0,5'd0,3'd0,8'h00,3'd4,32'h0,32'h11223344,2'd0,32'h11223344,32'h0},
        '{1'b0,1'b0,1'b0,8'd0,5'd12,3'd3,8'h0E,3'd2,32'h0,32'hAABBCCDD,2'd0,32'h0000AABB,32'h0},
        '{1'b0,1'b0,1'b0,8'd0,5'd9,3'd1,8'h3D,3'd1,32'h0,32'h55667788,2'd0,32'h00000077,32'h0},
        '{1'b0,1'b0,1'b0,8'd0,5'd16,3'd0,8'h00,3'd4,32'h0,32'h0,2'd2,32'h0,32'h0},
        '{1'b0,1'b0,1'b0,8'd5,5'd31,3'd7,8'hFF,3'd1,32'h0,32'h9ABCDEF0,2'd0,32'h0000009A,32'h0},
        '{1'b0,1'b0,1'b0,8'd1,5'd2,3'd0,8'h00,3'd3,32'h0,32'h0,2'd1,32'h0,32'h0},
        '{1'b1,1'b0,1'b0,8'd0,5'd2,3'd0,8'h00,3'd0,32'h5,32'h0,2'd1,32'h0,32'h0},
        '{1'b1,1'b0,1'b0,8'd0,5'd1,3'd0,8'h05,3'd1,32'h123456AB,32'hFFFFFFFF,2'd0,32'h0,32'hFFFFABFF},
        '{1'b1,1'b0,1'b0,8'd2,5'd3,3'd0,8'h06,3'd2,32'h0000BEEF,32'h0,2'd0,32'h0,32'hBEEF0000},
        '{1'b1,1'b0,1'b0,8'd0,5'd2,3'd0,8'h10,3'd4,32'hCAFEF00D,32'h12345678,2'd0,32'h0,32'hCAFEF00D},
        '{1'b0,1'b1,1'b0,8'd0,5'd1,3'd0,8'h00,3'd4,32'h0,32'h0,2'd2,32'h0,32'h0},
        '{1'b0,1'b1,1'b0,8'd0,5'd0,3'd2,8'h08,3'd4,32'h0,32'h0BADF00D,2'd0,32'h0BADF00D,32'h0},
        '{1'b0,1'b1,1'b0,8'd3,5'd1,3'd0,8'h00,3'd4,32'h0,32'h0,2'd2,32'h0,32'h0},
        '{1'b0,1'b0,1'b1,8'd0,5'd4,3'd0,8'h00,3'd4,32'h0,32'h0,2'd3,32'hFFFFFFFF,32'h0},
        '{1'b1,1'b0,1'b1,8'd1,5'd0,3'd0,8'h01,3'd1,32'h77,32'h0,2'd3,32'hFFFFFFFF,32'h0},
        '{1'b0,1'b0,1'b0,8'd0,5'd15,3'd0,8'h40,3'd4,32'h0,32'h01020304,2'd0,32'h01020304,32'h0},
        '{1'b0,1'b0,1'b0,8'd0,5'd3,3'd0,8'h03,3'd2,32'h0,32'hDEADBEEF,2'd0,32'h000000DE,32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, cardbus_mode = 1'b0;
    logic [7:0]  req_bus = '0, req_off = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0, req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, rsp_valid, mem_req, mem_we;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_rdata, win_reg, mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0, mem_err = 1'b0;

    logic [31:0] mem_word = '0;
    logic        err_inj = 1'b0;
    int          n_rd = 0, n_wr = 0, n_rsp = 0;
    logic [31:0] last_addr = '0, last_wword = '0;
    int          total = 0, bad = 0;
    logic [1:0]  got_st;
    logic [31:0] got_rd;

    always #2 clk = ~clk;

    pcicfg_xlate i_pcicfg_xlate (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func), .req_off(req_off),
        .req_size(req_size), .req_wdata(req_wdata), .cardbus_mode(cardbus_mode),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .win_reg(win_reg), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err)
    );

    // downstream bus model: acknowledge each request one half cycle later
    always @(negedge clk) begin
        if (rsp_valid) n_rsp = n_rsp + 1;
        if (mem_ack) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end else if (mem_req) begin
            mem_ack   = 1'b1;
            mem_err   = err_inj;
            mem_rdata = mem_word;
            last_addr = mem_addr;
            if (mem_we) begin
                n_wr = n_wr + 1;
                last_wword = mem_wdata;
            end else begin
                n_rd = n_rd + 1;
            end
        end
    end

    function automatic logic [31:0] model_win(input logic [7:0] b, input logic [4:0] d);
        logic [31:0] oh;
        oh = 32'h1 << (32'(d) + 16);
        if (b == 8'd0) return 32'h2 | (oh & 32'hFC000000);
        return 32'h3;
    endfunction

    function automatic logic [31:0] model_addr(input logic [7:0] b, input logic [4:0] d,
                                               input logic [2:0] f, input logic [7:0] o);
        logic [31:0] oh;
        oh = 32'h1 << (32'(d) + 16);
        if (b == 8'd0)
            return 32'h0C000000 | (oh & 32'h03FFFFFF) | (32'(f) << 8) | 32'(o & 8'hFC);
        return 32'h0C000000 | (32'(b) << 16) | (32'(d) << 11) | (32'(f) << 8) | 32'(o & 8'hFC);
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic run_req(input vec_t v);
        int waited;
        @(negedge clk);
        n_rd = 0; n_wr = 0; n_rsp = 0;
        mem_word = v.mem; err_inj = v.err; cardbus_mode = v.cb;
        req_write = v.wr; req_bus = v.bus; req_dev = v.dev; req_func = v.func;
        req_off = v.off; req_size = v.size; req_wdata = v.wdata; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0;
        while (!rsp_valid && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        got_st = rsp_status;
        got_rd = rsp_rdata;
        @(negedge clk);
        chk(!rsp_valid && !busy, "R10 pulse then idle", {30'd0, rsp_valid, busy}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog: act=%h exp=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        logic [31:0] exp_win;
        repeat (3) @(negedge clk);
        chk(!busy && !rsp_valid && !mem_req, "R11 reset outputs", {29'd0, busy, rsp_valid, mem_req}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(win_reg == 32'h2, "R11 reset window", win_reg, 32'h2);
        chk(!busy && !mem_req, "R11 idle after reset", {30'd0, busy, mem_req}, 32'h0);
        exp_win = 32'h2;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int er, ew;
            string tag;
            v = VECS[i];
            run_req(v);
            tag = $sformatf("vec%0d R1 R2 R3 R4 R8 status", i);
            chk(got_st == v.exp_st, tag, 32'(got_st), 32'(v.exp_st));
            if (v.exp_st == 2'd1 || v.exp_st == 2'd2) begin
                er = 0; ew = 0;
            end else begin
                exp_win = model_win(v.bus, v.dev);
                er = (v.wr && v.size == 3'd4) ? 0 : 1;
                ew = (v.wr && v.exp_st == 2'd0) ? 1 : 0;
            end
            chk(win_reg == exp_win, $sformatf("vec%0d R2 R3 R9 window", i), win_reg, exp_win);
            chk(n_rd == er, $sformatf("vec%0d R1 R6 R7 R8 reads", i), 32'(n_rd), 32'(er));
            chk(n_wr == ew, $sformatf("vec%0d R1 R6 R7 R8 writes", i), 32'(n_wr), 32'(ew));
            if (er + ew > 0)
                chk(last_addr == model_addr(v.bus, v.dev, v.func, v.off),
                    $sformatf("vec%0d R2 R3 address", i), last_addr,
                    model_addr(v.bus, v.dev, v.func, v.off));
            if (!v.wr || v.exp_st == 2'd3)
                chk(got_rd == v.exp_rd, $sformatf("vec%0d R5 R8 read data", i), got_rd, v.exp_rd);
            if (ew == 1)
                chk(last_wword == v.exp_word, $sformatf("vec%0d R6 R7 written word", i),
                    last_wword, v.exp_word);
        end

        // R10: a second request while busy is dropped
        @(negedge clk);
        n_rd = 0; n_wr = 0; n_rsp = 0;
        mem_word = 32'hA5A5A5A5; err_inj = 1'b0; cardbus_mode = 1'b0;
        req_write = 1'b0; req_bus = 8'd0; req_dev = 5'd0; req_func = 3'd0;
        req_off = 8'h00; req_size = 3'd4; req_valid = 1'b1;
        @(negedge clk);
        req_bus = 8'd7; req_dev = 5'd4;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        chk(n_rsp == 1, "R10 one response while busy", 32'(n_rsp), 32'd1);
        chk(n_rd == 1 && n_wr == 0, "R10 one access while busy", 32'(n_rd), 32'd1);
        chk(win_reg == 32'h2, "R10 busy request left window", win_reg, 32'h2);
        chk(last_addr == 32'h0C010000, "R10 first request address", last_addr, 32'h0C010000);

        finish_run();
    end
endmodule